// File: doc/BRIEF.md
# Configurable Four-Input Lookup Logic Cell

This block is one logic cell of a programmable fabric. A four-input lookup table holds sixteen function bits and three mode bits. All nineteen bits are shifted in one at a time through a serial configuration port. The table computes any Boolean function of its four inputs. Three of those inputs are fixed: data1, data2 and data4. The fourth is either data3 or the carry input, as a mode bit selects. The table result leaves the cell twice, unregistered: once as the combinational output and once as the lookup-chain output for the next cell.

The lookup result feeds a single-bit register. That register has an active-low asynchronous clear, an asynchronous load from data3, a clock enable, a synchronous clear and a synchronous load. Its data input can come from three places. In normal use it is the table result. In packed mode it is data4 taken directly, so the table and the register carry unrelated functions. It can also be the register-chain input from a neighbouring cell. The register value leaves the cell on both the registered output and the register-chain output.

Top module: `lcell_top`

## Requirements
- R1: `comb_out` equals mask bit number {in3,in2,in1,in0}, where in0 = `data1`, in1 = `data2`, in3 = `data4`, and in2 is the selected third input; the mask is configuration bits 15:0.
- R2: Configuration bit 16 selects the in2 source: 1 takes `carry_in`, 0 takes `data3`.
- R3: On each rising clock edge with `cfg_en` high, `cfg_bit` enters at configuration bit 18 and every other bit moves one place toward bit 0, so the first of nineteen bits written ends in bit 0; with `cfg_en` low the configuration is unchanged whatever `cfg_bit` does.
- R4: While `aclr_n` is low the register reads 0 at once, even while `aload` is high and across clock edges.
- R5: A rising `aload` with `aclr_n` high sets the register to `data3` without waiting for a clock edge.
- R6: With `ena` low and no asynchronous control active, the register holds its value across clock edges.
- R7: With `ena` high, `sclr` high forces the register to 0 at the next edge, taking priority over `sload`.
- R8: With `ena` high, `sclr` low and `sload` high, the register takes `data3` at the next edge, taking priority over its data input.
- R9: With bits 17 and 18 both 0, an enabled edge with no synchronous control stores the lookup result.
- R10: With bit 17 set and bit 18 clear (packed), an enabled edge stores `data4`, while `comb_out` still follows the table.
- R11: With bit 18 set, an enabled edge stores `reg_chain_in`, whatever bit 17 says.
- R12: `lut_chain_out` always equals `comb_out`, and `reg_chain_out` always equals `reg_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register and the configuration shifter |
| aclr_n | input | 1 | Asynchronous clear of the register, active low |
| aload | input | 1 | Asynchronous load of data3 into the register |
| ena | input | 1 | Clock enable for all synchronous register actions |
| sclr | input | 1 | Synchronous clear |
| sload | input | 1 | Synchronous load of data3 |
| cfg_en | input | 1 | Shifts cfg_bit into the configuration when high |
| cfg_bit | input | 1 | Serial configuration data |
| data1 | input | 1 | Table input in0 |
| data2 | input | 1 | Table input in1 |
| data3 | input | 1 | Optional table input in2; load data |
| data4 | input | 1 | Table input in3; packed-mode register data |
| carry_in | input | 1 | Alternative table input in2 |
| reg_chain_in | input | 1 | Register data from the neighbouring cell |
| comb_out | output | 1 | Unregistered table result |
| lut_chain_out | output | 1 | Table result toward the next cell |
| reg_out | output | 1 | Register value |
| reg_chain_out | output | 1 | Register value toward the next cell |

## Verification
The register properties assume that `aload` changes only between clock edges, and that `data3` stays steady while `aload` is high. Without both, the next-cycle value is not defined by the edge alone. The properties also assume that the configuration shifter is observed only after reset has been released. The stimulus drives every input at the falling clock edge. It raises and drops `aload` at falling edges with `data3` already settled. It loads a full nineteen-bit configuration after reset and before any lookup result is compared.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
    localparam int LUT_K     = 4;
    localparam int LUT_BITS  = 1 << LUT_K;
    localparam int MODE_BITS = 3;
    localparam int CFG_W     = LUT_BITS + MODE_BITS;

    // Layout matches the serial order: mask in the low bits, modes above.
    typedef struct packed {
        logic                chain_sel;   // bit 18
        logic                pack_en;     // bit 17
        logic                use_cin;     // bit 16
        logic [LUT_BITS-1:0] mask;        // bits 15:0
    } cell_cfg_t;

    typedef enum logic [1:0] {
        SRC_LUT   = 2'd0,
        SRC_PACK  = 2'd1,
        SRC_CHAIN = 2'd2
    } dsrc_e;
endpackage

// File: rtl/lcell_cfg.sv
module lcell_cfg
    import lcell_pkg::*;
(
    input  logic       clk,
    input  logic       aclr_n,
    input  logic       cfg_en,
    input  logic       cfg_bit,
    output cell_cfg_t  cfg
);
    typedef struct packed {
        logic [CFG_W-1:0] sh;
    } cfg_state_t;

    cfg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cfg_en) begin
            s_d.sh = {cfg_bit, s_q.sh[CFG_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign cfg = cell_cfg_t'(s_q.sh);

    // R3: a write lands in the top bit
    p_shift_in_r3: assert property (@(posedge clk) disable iff (!aclr_n)
        cfg_en |=> (s_q.sh[CFG_W-1] == $past(cfg_bit)));

    // R3: configuration holds without the enable
    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!aclr_n)
        !cfg_en |=> $stable(s_q.sh));
endmodule

// File: rtl/lcell_lut.sv
module lcell_lut
    import lcell_pkg::*;
(
    input  logic [LUT_BITS-1:0] mask,
    input  logic                use_cin,
    input  logic                data1,
    input  logic                data2,
    input  logic                data3,
    input  logic                data4,
    input  logic                carry_in,
    output logic                f
);
    logic [LUT_K-1:0] sel_d;

    always_comb begin
        sel_d = {data4, (use_cin ? carry_in : data3), data2, data1};
        f     = mask[sel_d];
    end
endmodule

// File: rtl/lcell_ff.sv
module lcell_ff (
    input  logic clk,
    input  logic aclr_n,
    input  logic aload,
    input  logic ena,
    input  logic sclr,
    input  logic sload,
    input  logic adata,
    input  logic d,
    output logic q
);
    typedef struct packed {
        logic q;
    } ff_state_t;

    ff_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ena) begin
            if (sclr) begin
                s_d.q = 1'b0;
            end else if (sload) begin
                s_d.q = adata;
            end else begin
                s_d.q = d;
            end
        end
    end

    always_ff @(posedge clk or negedge aclr_n or posedge aload) begin
        if (!aclr_n) begin
            s_q <= '0;
        end else if (aload) begin
            s_q <= '{q: adata};
        end else begin
            s_q <= s_d;
        end
    end

    assign q = s_q.q;

    p_hold_r6: assert property (@(posedge clk) disable iff (!aclr_n)
        (!ena && !aload) |=> (aload || $stable(s_q.q)));

    p_sclr_r7: assert property (@(posedge clk) disable iff (!aclr_n)
        (ena && sclr && !aload) |=> (aload || (s_q.q == 1'b0)));

    p_sload_r8: assert property (@(posedge clk) disable iff (!aclr_n)
        (ena && !sclr && sload && !aload) |=> (aload || (s_q.q == $past(adata))));
endmodule

// File: rtl/lcell_top.sv
module lcell_top
    import lcell_pkg::*;
(
    input  logic clk,
    input  logic aclr_n,
    input  logic aload,
    input  logic ena,
    input  logic sclr,
    input  logic sload,
    input  logic cfg_en,
    input  logic cfg_bit,
    input  logic data1,
    input  logic data2,
    input  logic data3,
    input  logic data4,
    input  logic carry_in,
    input  logic reg_chain_in,
    output logic comb_out,
    output logic lut_chain_out,
    output logic reg_out,
    output logic reg_chain_out
);
    cell_cfg_t cfg;
    logic      lut_f;
    logic      ff_d;
    logic      ff_q;
    dsrc_e     src;

    lcell_cfg u_cfg (
        .clk     (clk),
        .aclr_n  (aclr_n),
        .cfg_en  (cfg_en),
        .cfg_bit (cfg_bit),
        .cfg     (cfg)
    );

    lcell_lut u_lut (
        .mask     (cfg.mask),
        .use_cin  (cfg.use_cin),
        .data1    (data1),
        .data2    (data2),
        .data3    (data3),
        .data4    (data4),
        .carry_in (carry_in),
        .f        (lut_f)
    );

    // Register source: chain beats packed, packed beats the table.
    always_comb begin
        if (cfg.chain_sel) begin
            src = SRC_CHAIN;
        end else if (cfg.pack_en) begin
            src = SRC_PACK;
        end else begin
            src = SRC_LUT;
        end
        case (src)
            SRC_CHAIN: ff_d = reg_chain_in;
            SRC_PACK:  ff_d = data4;
            default:   ff_d = lut_f;
        endcase
    end

    lcell_ff u_ff (
        .clk    (clk),
        .aclr_n (aclr_n),
        .aload  (aload),
        .ena    (ena),
        .sclr   (sclr),
        .sload  (sload),
        .adata  (data3),
        .d      (ff_d),
        .q      (ff_q)
    );

    assign comb_out      = lut_f;
    assign lut_chain_out = lut_f;
    assign reg_out       = ff_q;
    assign reg_chain_out = ff_q;
endmodule

// File: tb/lcell_top_test.sv
`timescale 1ns/1ps
module lcell_top_test;
    logic clk = 1'b0;
    logic aclr_n = 1'b0, aload = 1'b0, ena = 1'b0, sclr = 1'b0, sload = 1'b0;
    logic cfg_en = 1'b0, cfg_bit = 1'b0;
    logic data1 = 1'b0, data2 = 1'b0, data3 = 1'b0, data4 = 1'b0;
    logic carry_in = 1'b0, reg_chain_in = 1'b0;
    logic comb_out, lut_chain_out, reg_out, reg_chain_out;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [18:0] m_cfg = '0;
    logic        m_q   = 1'b0;

    typedef struct {
        logic  comb;
        logic  q;
        string tag;
    } exp_t;
    exp_t sbq[$];

    always #2 clk = ~clk;

    lcell_top uut (
        .clk(clk), .aclr_n(aclr_n), .aload(aload), .ena(ena), .sclr(sclr),
        .sload(sload), .cfg_en(cfg_en), .cfg_bit(cfg_bit), .data1(data1),
        .data2(data2), .data3(data3), .data4(data4), .carry_in(carry_in),
        .reg_chain_in(reg_chain_in), .comb_out(comb_out),
        .lut_chain_out(lut_chain_out), .reg_out(reg_out),
        .reg_chain_out(reg_chain_out)
    );

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    // R1/R2: expected table output from the stated index order
    function automatic logic lut_model(input logic [3:0] d, input logic c);
        logic [3:0] idx;
        idx = {d[3], (m_cfg[16] ? c : d[2]), d[1], d[0]};
        return m_cfg[idx];
    endfunction

    // R3: first bit sent ends in bit 0
    task automatic load_cfg(input logic [18:0] c);
        @(negedge clk);
        ena = 1'b0;
        for (int i = 0; i < 19; i++) begin
            cfg_en  = 1'b1;
            cfg_bit = c[i];
            @(negedge clk);
        end
        cfg_en = 1'b0;
        m_cfg  = c;
    endtask

    // driver: d = {data4,data3,data2,data1}
    task automatic vec(input logic [3:0] d, input logic c, input logic e,
                       input logic sc, input logic sl, input logic rc, input string tag);
        exp_t x;
        @(negedge clk);
        {data4, data3, data2, data1} = d;
        carry_in = c; ena = e; sclr = sc; sload = sl; reg_chain_in = rc;
        x.comb = lut_model(d, c);
        if (e) begin
            if (sc)             m_q = 1'b0;
            else if (sl)        m_q = d[2];
            else if (m_cfg[18]) m_q = rc;
            else if (m_cfg[17]) m_q = d[3];
            else                m_q = x.comb;
        end
        x.q   = m_q;
        x.tag = tag;
        @(posedge clk);
        #1;
        sbq.push_back(x);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sbq.size() > 0) begin
                exp_t x;
                x = sbq.pop_front();
                check(comb_out, x.comb, x.tag, "comb_out");
                check(lut_chain_out, x.comb, {x.tag, " R12"}, "lut_chain_out");
                check(reg_out, x.q, x.tag, "reg_out");
                check(reg_chain_out, x.q, {x.tag, " R12"}, "reg_chain_out");
            end
        end
    end

    task automatic pulse_aload(input logic v);
        @(negedge clk);
        ena = 1'b0; data3 = v; aload = 1'b1;
        #0.5;
        check(reg_out, v, "R5", "aload immediate");
        m_q = v;
        @(negedge clk);
        aload = 1'b0;
        #0.5;
        check(reg_out, v, "R5", "after aload");
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(reg_out, 1'b0, "R4", "reset reg_out");
        check(reg_chain_out, 1'b0, "R12", "reset reg_chain_out");
        aclr_n = 1'b1;

        // normal mode, third input from data3
        load_cfg({3'b000, 16'hA5C3});
        for (int i = 0; i < 16; i++) vec(4'(i), ~i[2], 1'b0, 1'b0, 1'b0, 1'b0, "R1/R6");
        for (int i = 0; i < 16; i++) vec(4'(15 - i), i[0], 1'b1, 1'b0, 1'b0, 1'b0, "R9");

        // configuration ignored without enable
        @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            cfg_bit = ~cfg_bit;
            @(negedge clk);
        end
        for (int i = 0; i < 16; i++) vec(4'(i), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");

        // third input from carry_in
        load_cfg({3'b001, 16'h36F0});
        for (int i = 0; i < 32; i++) vec(4'(i), i[4], 1'b1, 1'b0, 1'b0, 1'b0, "R2");

        // synchronous controls
        vec(4'b0100, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R8");
        vec(4'b0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
        vec(4'b0100, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R8");
        vec(4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
        vec(4'b0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R8");
        vec(4'b1111, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R6");

        // packed: register from data4, table independent
        load_cfg({3'b010, 16'h00FF});
        for (int i = 0; i < 16; i++) vec(4'(i), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R10");

        // chain source beats packed
        load_cfg({3'b110, 16'h5A5A});
        for (int i = 0; i < 16; i++) vec(4'(i), 1'b0, 1'b1, 1'b0, 1'b0, ~i[1], "R11");

        // asynchronous load
        pulse_aload(1'b1);
        pulse_aload(1'b0);
        pulse_aload(1'b1);

        // clear beats load
        @(negedge clk);
        data3 = 1'b1; aload = 1'b1;
        #0.5;
        aclr_n = 1'b0;
        #0.5;
        check(reg_out, 1'b0, "R4", "clear over aload");
        @(negedge clk);
        check(reg_out, 1'b0, "R4", "clear across edge");
        aload = 1'b0;
        #0.5;
        aclr_n = 1'b1;
        m_q = 1'b0;
        vec(4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule